// File: doc/BRIEF.md
# Banked Memory Paging Controller

This block sits between an 8-bit CPU bus with 16-bit addresses and a physical store. The store is built from two 16 KB ROM pages and eight 16 KB RAM banks. The CPU selects the mapping by writing a small paging register through I/O space. On every memory cycle the block turns the CPU address into a 4-bit physical page index and a 14-bit offset. It blocks writes aimed at ROM, and it raises a flag when an access lands in the RAM window that the video logic shares, so that a later stage can stall it.

The 64 KB CPU space is split into four 16 KB windows. The lowest window holds one of the two ROM pages. The second window always shows RAM bank 5, and the third always shows RAM bank 2. The top window shows whichever RAM bank the register selects. A separate register bit tells the video side whether it scans bank 5 or bank 7. A one-way lock bit can freeze the register until the next reset. The block also exports the screen-bank number directly.

Top module: `bank_pager`

## Requirements
- R1: The paging register loads only when `iorq_n` is 0, address bit 15 is 0, address bit 1 is 0, and a read or write strobe is active. For example, 0xFFFD and 0x7FFF leave it unchanged, while 0x0000 and 0x7FFD both load it. Memory writes never load it.
- R2: Register bits 2..0 pick RAM bank k for window 0xC000-0xFFFF, which gives physical page index 2+k.
- R3: Register bit 3 drives `screen_bank`: 0 gives 5 and 1 gives 7.
- R4: Register bit 4 picks the ROM page for window 0x0000-0x3FFF, which gives page index 0 or 1.
- R5: Once a load sets register bit 5, every later load is ignored until reset.
- R6: Window 0x4000-0x7FFF always maps to page index 7 (RAM 5), and window 0x8000-0xBFFF always maps to page index 4 (RAM 2).
- R7: `mem_we` is 1 only when `mreq_n` and `wr_n` are both 0 and the address is at 0x4000 or above. Writes to ROM are dropped.
- R8: An I/O read that decodes to the register loads 0x3F, the same as writing 0xFF, unless the lock is already set.
- R9: After reset the register is 0: RAM 0 at the top window, ROM 0, screen bank 5, unlocked.
- R10: `contend` is 1 exactly when `mreq_n` is 0 and the address lies in 0x4000-0x7FFF.
- R11: `phys_offset` equals address bits 13..0. The page indices are 0 for ROM 0, 1 for ROM 1, and 2+k for RAM k. Data bits 7..6 are ignored.
- R12: A load becomes visible at the outputs after the clock edge on which the strobe is sampled, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU data for I/O writes |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| phys_page | output | 4 | Physical page index |
| phys_offset | output | 14 | Offset within the page |
| mem_we | output | 1 | Write enable to the physical store |
| mem_re | output | 1 | Read enable to the physical store |
| contend | output | 1 | Access falls in the display-shared window |
| screen_bank | output | 3 | RAM bank the video logic scans |

## Verification
A wrong latched value shows up on `phys_page` for the ROM window or the top window, or on `screen_bank`, on the first memory cycle after the faulty load. A stuck or missing lock shows up on the first load that follows it. The sweep loads every 6-bit register value with junk in the upper data bits, then probes each window at its low edge, its middle and its high edge. Separate sequences cover port aliasing, the read-as-0xFF rule, lock persistence across both loads and reads, and the exact cycle in which a load appears.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int ROM_PAGES  = 2;
  localparam int RAM_BANKS  = 8;
  localparam int BANK_W     = $clog2(RAM_BANKS);
  localparam int PAGE_IDX_W = $clog2(ROM_PAGES + RAM_BANKS);

  // Field order follows the data-bit positions the CPU writes.
  typedef struct packed {
    logic              lock;
    logic              rom;
    logic              scr;
    logic [BANK_W-1:0] ram;
  } page_cfg_t;

  localparam int CFG_W = $bits(page_cfg_t);
endpackage

// File: rtl/bp_rst_sync.sv
module bp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_d = 1'b1;
    end else begin : g_many
      always_comb sr_d = {sr_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_n_sync = sr_q[STAGES-1];
endmodule

// File: rtl/bp_port_decode.sv
module bp_port_decode import bp_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              locked,
  output logic              ld_en,
  output page_cfg_t         ld_cfg
);
  logic hit;
  logic io_wr;
  logic io_rd;

  always_comb begin
    hit    = !iorq_n && !addr[ADDR_W-1] && !addr[1];
    io_wr  = hit && !wr_n;
    io_rd  = hit && !rd_n && wr_n;
    ld_en  = (io_wr || io_rd) && !locked;
    // A read loads the all-ones pattern.
    ld_cfg = io_wr ? page_cfg_t'(wdata[CFG_W-1:0]) : page_cfg_t'({CFG_W{1'b1}});
  end
endmodule

// File: rtl/bp_page_latch.sv
module bp_page_latch import bp_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_en,
  input  page_cfg_t ld_cfg,
  output page_cfg_t cfg
);
  page_cfg_t cfg_q;
  page_cfg_t cfg_d;

  always_comb cfg_d = ld_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (ld_en) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/bp_addr_xlate.sv
module bp_addr_xlate import bp_pkg::*; #(
  parameter int ADDR_W        = 16,
  parameter int OFF_W         = 14,
  parameter int FIXED_LO_BANK = 5,
  parameter int FIXED_HI_BANK = 2
) (
  input  logic [ADDR_W-1:0]     addr,
  input  page_cfg_t             cfg,
  input  logic                  mreq_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  output logic [PAGE_IDX_W-1:0] page,
  output logic [OFF_W-1:0]      offset,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic                  contend
);
  localparam int WIN_W = ADDR_W - OFF_W;
  localparam logic [PAGE_IDX_W-1:0] LO_PAGE = PAGE_IDX_W'(ROM_PAGES + FIXED_LO_BANK);
  localparam logic [PAGE_IDX_W-1:0] HI_PAGE = PAGE_IDX_W'(ROM_PAGES + FIXED_HI_BANK);

  logic [WIN_W-1:0] win;
  logic             in_rom;
  logic             in_shared;

  always_comb begin
    win       = addr[ADDR_W-1:OFF_W];
    in_rom    = (win == WIN_W'(0));
    in_shared = (win == WIN_W'(1));
    case (win)
      WIN_W'(0): page = PAGE_IDX_W'(cfg.rom);
      WIN_W'(1): page = LO_PAGE;
      WIN_W'(2): page = HI_PAGE;
      default:   page = PAGE_IDX_W'(ROM_PAGES) + PAGE_IDX_W'(cfg.ram);
    endcase
    offset  = addr[OFF_W-1:0];
    mem_we  = !mreq_n && !wr_n && !in_rom;
    mem_re  = !mreq_n && !rd_n;
    contend = !mreq_n && in_shared;
  end
endmodule

// File: rtl/bank_pager.sv
module bank_pager import bp_pkg::*; #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int OFF_W         = 14,
  parameter int RST_STAGES    = 2,
  parameter int FIXED_LO_BANK = 5,
  parameter int FIXED_HI_BANK = 2,
  parameter int SCR_ALT_BANK  = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [DATA_W-1:0]     cpu_wdata,
  input  logic                  iorq_n,
  input  logic                  mreq_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  output logic [PAGE_IDX_W-1:0] phys_page,
  output logic [OFF_W-1:0]      phys_offset,
  output logic                  mem_we,
  output logic                  mem_re,
  output logic                  contend,
  output logic [BANK_W-1:0]     screen_bank
);
  logic      rst_n_i;
  logic      ld_en;
  page_cfg_t ld_cfg;
  page_cfg_t cfg_q;

  bp_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  bp_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr   (cpu_addr),
    .wdata  (cpu_wdata),
    .iorq_n (iorq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .locked (cfg_q.lock),
    .ld_en  (ld_en),
    .ld_cfg (ld_cfg)
  );

  bp_page_latch u_lat (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .ld_en  (ld_en),
    .ld_cfg (ld_cfg),
    .cfg    (cfg_q)
  );

  bp_addr_xlate #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .FIXED_LO_BANK(FIXED_LO_BANK), .FIXED_HI_BANK(FIXED_HI_BANK)
  ) u_xl (
    .addr    (cpu_addr),
    .cfg     (cfg_q),
    .mreq_n  (mreq_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .page    (phys_page),
    .offset  (phys_offset),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .contend (contend)
  );

  assign screen_bank = cfg_q.scr ? BANK_W'(SCR_ALT_BANK) : BANK_W'(FIXED_LO_BANK);
endmodule

// File: rtl/bank_pager_chk.sv
module bank_pager_chk import bp_pkg::*; #(
  parameter int ADDR_W        = 16,
  parameter int OFF_W         = 14,
  parameter int FIXED_LO_BANK = 5,
  parameter int SCR_ALT_BANK  = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     cpu_addr,
  input logic                  iorq_n,
  input logic                  mreq_n,
  input logic                  rd_n,
  input logic                  wr_n,
  input logic [PAGE_IDX_W-1:0] phys_page,
  input logic                  mem_we,
  input logic                  contend,
  input logic [BANK_W-1:0]     screen_bank,
  input logic [CFG_W-1:0]      cfg_bits
);
  logic [1:0] win;
  assign win = cpu_addr[ADDR_W-1 -: 2];

  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bits[CFG_W-1] |=> cfg_bits[CFG_W-1]);

  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bits[CFG_W-1] |=> $stable(cfg_bits));

  a_r1_no_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n || cpu_addr[ADDR_W-1] || cpu_addr[1] || (rd_n && wr_n)) |=> $stable(cfg_bits));

  a_r7_rom_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 2'd0) |-> !mem_we);

  a_r6_fixed_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (win == 2'd1) |-> (phys_page == PAGE_IDX_W'(ROM_PAGES + FIXED_LO_BANK)));

  a_r3_screen_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (screen_bank == BANK_W'(FIXED_LO_BANK)) || (screen_bank == BANK_W'(SCR_ALT_BANK)));

  a_r10_contend_window: assert property (@(posedge clk) disable iff (!rst_n)
    contend |-> (!mreq_n && win == 2'd1));
endmodule

bind bank_pager bank_pager_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W),
  .FIXED_LO_BANK(FIXED_LO_BANK), .SCR_ALT_BANK(SCR_ALT_BANK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .iorq_n      (iorq_n),
  .mreq_n      (mreq_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .phys_page   (phys_page),
  .mem_we      (mem_we),
  .contend     (contend),
  .screen_bank (screen_bank),
  .cfg_bits    (cfg_q)
);

// File: tb/bank_pager_bench.sv
`timescale 1ns/1ps
module bank_pager_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        iorq_n, mreq_n, rd_n, wr_n;
  logic [3:0]  phys_page;
  logic [13:0] phys_offset;
  logic        mem_we, mem_re, contend;
  logic [2:0]  screen_bank;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bank_pager u_bank_pager (
    .clk(clk), .rst_n(rst_n), .cpu_addr(addr), .cpu_wdata(wdata),
    .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .phys_page(phys_page), .phys_offset(phys_offset), .mem_we(mem_we),
    .mem_re(mem_re), .contend(contend), .screen_bank(screen_bank)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); idle();
  endtask

  task automatic io_rd(input logic [15:0] a);
    @(negedge clk); addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); idle();
  endtask

  function automatic int exp_page(input int w, input logic [5:0] c);
    case (w)
      0: return int'(c[4]);
      1: return 7;
      2: return 4;
      default: return 2 + int'(c[2:0]);
    endcase
  endfunction

  // Probe every window at three offsets with memory writes and reads.
  task automatic probe(input logic [5:0] c, input string tag);
    int offs[3] = '{0, 'h1555, 'h3FFF};
    check({tag, " R3 screen_bank"}, int'(screen_bank), c[3] ? 7 : 5);
    for (int w = 0; w < 4; w++) begin
      for (int k = 0; k < 3; k++) begin
        addr = 16'((w << 14) | offs[k]);
        mreq_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1;
        #1;
        check({tag, (w == 0) ? " R4 page" : (w == 3) ? " R2 page" : " R6 page"},
              int'(phys_page), exp_page(w, c));
        check({tag, " R11 offset"}, int'(phys_offset), offs[k]);
        check({tag, " R7 mem_we"}, int'(mem_we), (w != 0) ? 1 : 0);
        check({tag, " R10 contend"}, int'(contend), (w == 1) ? 1 : 0);
        wr_n = 1'b1; rd_n = 1'b0;
        #1;
        check({tag, " R7 read no we"}, int'(mem_we), 0);
        idle();
        #1;
        check({tag, " R10 idle contend"}, int'(contend), 0);
      end
    end
    idle();
  endtask

  initial begin
    addr = '0; wdata = '0; rst_n = 1'b0; idle();
    do_reset();
    probe(6'h00, "R9 reset");

    // Full sweep of register values with ignored high data bits (R11).
    for (int v = 0; v < 64; v++) begin
      do_reset();
      io_wr(16'h7FFD, 8'(v) | 8'hC0);
      probe(6'(v), "R2/R3/R4 sweep");
    end

    // Decode: R1
    do_reset();
    io_wr(16'hFFFD, 8'h17);
    probe(6'h00, "R1 A15 high");
    io_wr(16'h7FFF, 8'h17);
    probe(6'h00, "R1 A1 high");
    io_wr(16'h0000, 8'h0A);
    probe(6'h0A, "R1 alias 0x0000");
    @(negedge clk); addr = 16'h7FFD; wdata = 8'h15; mreq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); idle();
    probe(6'h0A, "R1 memory write");

    // Lock: R5
    do_reset();
    io_wr(16'h7FFD, 8'h23);
    probe(6'h23, "R5 lock set");
    io_wr(16'h7FFD, 8'h1C);
    probe(6'h23, "R5 write ignored");
    io_rd(16'h7FFD);
    probe(6'h23, "R8 locked read ignored");
    do_reset();
    probe(6'h00, "R9 lock cleared");

    // Read acts as 0xFF: R8
    do_reset();
    io_wr(16'h7FFD, 8'h01);
    io_rd(16'h7FFD);
    probe(6'h3F, "R8 read loads ones");
    io_wr(16'h7FFD, 8'h00);
    probe(6'h3F, "R8 read set lock");

    // Timing: R12
    do_reset();
    @(negedge clk); addr = 16'h7FFD; wdata = 8'h18; iorq_n = 1'b0; wr_n = 1'b0;
    #1;
    check("R12 before edge screen", int'(screen_bank), 5);
    @(negedge clk); idle();
    #1;
    check("R12 after edge screen", int'(screen_bank), 7);
    probe(6'h18, "R12 after edge");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule